// File: doc/BRIEF.md
# Dual-Output Register/Buffer Bus Driver

This block takes one 12-bit input bus and presents it on two identical 12-bit output copies. A mode select chooses the source of both copies. In register mode they show a bank of rising-edge flip-flops. In buffer mode the input passes straight through without waiting for a clock.

The register bank is split in two. The upper four bits load on every rising edge. The lower eight bits load only while the active-low load enable is asserted, and otherwise keep their value. The register bank follows these rules in both modes. Returning from buffer mode to register mode therefore shows whatever was last captured.

A single active-low output enable controls whether the two copies drive. Each copy is modelled as a data value plus a drive flag, so the block stays synthesizable. The output enable has no effect on the register bank.

Top module: `dual_bus_driver`

## Requirements
- R1: With `buf_mode` low, both output copies show the register bank, and they change only after a rising clock edge.
- R2: With `buf_mode` high, both output copies equal `a_in` in the same cycle, with no clock edge needed.
- R3: When `load_n` is low at a rising edge (and reset is inactive), all 12 register bits take the value of `a_in`.
- R4: When `load_n` is high at a rising edge, bits 11..8 of the register (bit 0 is the LSB) take `a_in[11:8]`, and bits 7..0 keep their previous value.
- R5: `y0_data` always equals `y1_data`, and `y0_drive` always equals `y1_drive`.
- R6: When `oe_n` is high, both drive flags are 0. When `oe_n` is low, both drive flags are 1. The data values keep showing the selected source in both cases.
- R7: `oe_n` does not affect the register bank. Values loaded while the outputs are released appear once the outputs are enabled again.
- R8: When `rst_n` is low at a rising edge, all register bits are cleared to 0. This takes priority over loading.
- R9: In buffer mode the register bank keeps loading under R3/R4. After a switch back to register mode, the outputs show the last captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for the register bank |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_mode | input | 1 | 1 selects the pass-through path, 0 selects the register path |
| load_n | input | 1 | Active-low load enable for register bits 7..0 |
| oe_n | input | 1 | Active-low output enable for both copies |
| a_in | input | 12 | Input data bus |
| y0_data | output | 12 | Data value of output copy 0 |
| y0_drive | output | 1 | Copy 0 drives when 1, high impedance when 0 |
| y1_data | output | 12 | Data value of output copy 1 |
| y1_drive | output | 1 | Copy 1 drives when 1, high impedance when 0 |

## Verification
The bench builds the block with its default widths: a 12-bit bus whose lower 8 bits are held when the load enable is deasserted. With this split, a single vector shows the difference between the always-loaded slice and the held slice, using nibble patterns such as 0x555 over 0xABC. Keeping those widths also lets the hand-computed expected values in the vector table cover these cases:
- partial loads that happen in buffer mode;
- loads made while the outputs are released;
- a reset that arrives together with an asserted load enable.

// File: rtl/dual_bus_driver_pkg.sv
// Package: shared widths and the data word type for the dual bus driver.
// Assumes a single data width used by every submodule.
package dual_bus_driver_pkg;
    localparam int BUS_W     = 12;
    localparam int KEEP_W    = 8;
    localparam int N_COPIES  = 2;
    typedef logic [BUS_W-1:0] bus_word_t;
endpackage

// File: rtl/bdrv_capture_bank.sv
// Module: register bank with a split load rule.
// Bits below KEEP_W load only when load_n is low; bits at or above
// KEEP_W load on every rising edge. A synchronous active-low reset clears
// every bit and takes priority over loading.
// Assumes KEEP_W <= DATA_W.
module bdrv_capture_bank #(
    parameter int DATA_W = 12,
    parameter int KEEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] q_out
);
    localparam int FREE_W = DATA_W - KEEP_W;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_bit
            if (gi < KEEP_W) begin : g_gated
                // Gated bit: load only when the enable is asserted.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q_out[gi] <= 1'b0;
                    else if (!load_n)
                        q_out[gi] <= d_in[gi];
                end
            end else begin : g_free
                // Free-running bit: load on every edge.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q_out[gi] <= 1'b0;
                    else
                        q_out[gi] <= d_in[gi];
                end
            end
        end
    endgenerate

    p_full_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (q_out == $past(d_in)))
        else $error("full load mismatch");

    p_keep_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> $stable(q_out[KEEP_W-1:0]))
        else $error("held slice changed");

    p_upper_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> (q_out[DATA_W-1:KEEP_W] == $past(d_in[DATA_W-1:KEEP_W])))
        else $error("upper slice not loaded");

    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (q_out == '0))
        else $error("reset did not clear");

    // FREE_W is used only to keep the derived width documented and checked.
    initial begin
        if (FREE_W < 0) $error("KEEP_W exceeds DATA_W");
    end
endmodule

// File: rtl/bdrv_out_copy.sv
// Module: one output copy. It selects the pass-through input or the
// register value and produces a data value plus a drive flag that stands
// in for a tri-state enable.
// Assumes the select and the enable are shared by all copies.
module bdrv_out_copy #(
    parameter int DATA_W = 12
) (
    input  logic              bypass,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] pass_val,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] data_out,
    output logic              drive_out
);
    // Source select and enable decode for this copy.
    always_comb begin
        data_out  = bypass ? pass_val : reg_val;
        drive_out = ~oe_n;
    end
endmodule

// File: rtl/dual_bus_driver.sv
// Module: top of the dual-output register/buffer bus driver.
// One register bank feeds N_COPIES identical output stages. buf_mode
// selects pass-through or registered data, and oe_n releases all copies.
// Assumes synchronous active-low reset and a single clock domain.
module dual_bus_driver
    import dual_bus_driver_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_mode,
    input  logic             load_n,
    input  logic             oe_n,
    input  logic [BUS_W-1:0] a_in,
    output logic [BUS_W-1:0] y0_data,
    output logic             y0_drive,
    output logic [BUS_W-1:0] y1_data,
    output logic             y1_drive
);
    bus_word_t bank_q;
    bus_word_t copy_data [N_COPIES];
    logic      copy_drv  [N_COPIES];

    bdrv_capture_bank #(.DATA_W(BUS_W), .KEEP_W(KEEP_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .d_in   (a_in),
        .q_out  (bank_q)
    );

    genvar ci;
    generate
        for (ci = 0; ci < N_COPIES; ci++) begin : g_copy
            bdrv_out_copy #(.DATA_W(BUS_W)) u_copy (
                .bypass    (buf_mode),
                .oe_n      (oe_n),
                .pass_val  (a_in),
                .reg_val   (bank_q),
                .data_out  (copy_data[ci]),
                .drive_out (copy_drv[ci])
            );
        end
    endgenerate

    // Map the copy array onto the named ports.
    always_comb begin
        y0_data  = copy_data[0];
        y0_drive = copy_drv[0];
        y1_data  = copy_data[1];
        y1_drive = copy_drv[1];
    end

    p_copies_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (y0_data == y1_data) && (y0_drive == y1_drive))
        else $error("copies differ");

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!y0_drive && !y1_drive))
        else $error("drive while released");

    p_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (y0_drive && y1_drive))
        else $error("no drive while enabled");

    p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        buf_mode |-> (y0_data == a_in))
        else $error("pass-through mismatch");

    p_regpath_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_mode |-> (y0_data == bank_q))
        else $error("register path mismatch");
endmodule

// File: tb/dual_bus_driver_tb.sv
module dual_bus_driver_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        buf_mode, load_n, oe_n;
    logic [11:0] a_in;
    logic [11:0] y0_data, y1_data;
    logic        y0_drive, y1_drive;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_bus_driver u_dut (
        .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode), .load_n(load_n),
        .oe_n(oe_n), .a_in(a_in), .y0_data(y0_data), .y0_drive(y0_drive),
        .y1_data(y1_data), .y1_drive(y1_drive)
    );

    // {buf_mode, load_n, oe_n, a_in[11:0], exp_data[11:0], exp_drive}
    localparam int NV = 11;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 12'hABC, 12'hABC, 1'b1},  // R3 full load
        {1'b0, 1'b1, 1'b0, 12'h555, 12'h5BC, 1'b1},  // R4 upper only
        {1'b0, 1'b1, 1'b1, 12'h123, 12'h1BC, 1'b0},  // R4 R6 released
        {1'b0, 1'b0, 1'b1, 12'hFED, 12'hFED, 1'b0},  // R7 load while released
        {1'b0, 1'b0, 1'b0, 12'h000, 12'h000, 1'b1},  // R7 R3 re-enabled
        {1'b1, 1'b0, 1'b0, 12'hA5A, 12'hA5A, 1'b1},  // R2 R9 bypass, bank loads
        {1'b1, 1'b1, 1'b0, 12'h3C3, 12'h3C3, 1'b1},  // R2 R9 bypass, partial load
        {1'b0, 1'b1, 1'b0, 12'hFFF, 12'hF5A, 1'b1},  // R9 R1 last captured low
        {1'b0, 1'b1, 1'b0, 12'h0FF, 12'h05A, 1'b1},  // R4 low held
        {1'b1, 1'b1, 1'b1, 12'h777, 12'h777, 1'b0},  // R2 R6 bypass released
        {1'b0, 1'b0, 1'b0, 12'h800, 12'h800, 1'b1}   // R3 R1
    };

    task automatic check_val(input string req, input logic [31:0] got,
                             input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [11:0] ed,
                             input logic edrv);
        check_val(req, {20'd0, y0_data}, {20'd0, ed});
        check_val(req, {31'd0, y0_drive}, {31'd0, edrv});
        check_val("R5", {19'd0, y1_drive, y1_data}, {19'd0, y0_drive, y0_data});
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; buf_mode = 1'b0; load_n = 1'b0; oe_n = 1'b0; a_in = 12'hFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state, with load asserted and nonzero input
        check_out("R8", 12'h000, 1'b1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {buf_mode, load_n, oe_n, a_in} = VEC[i][27:13];
            @(posedge clk);
            @(negedge clk);
            check_out($sformatf("R1 vec%0d", i), VEC[i][12:1], VEC[i][0]);
        end

        // R2: pass-through responds with no clock edge
        buf_mode = 1'b1; a_in = 12'h2D4;
        #1 check_out("R2", 12'h2D4, 1'b1);
        a_in = 12'h93E;
        #0.5 check_out("R2", 12'h93E, 1'b1);

        // R1: register path does not move between edges
        @(negedge clk);
        buf_mode = 1'b0; load_n = 1'b1; a_in = 12'h111;
        #1 check_out("R1", 12'h93E, 1'b1);  // bank loaded 93E on the last edge
        @(posedge clk);
        @(negedge clk);
        check_out("R4", 12'h13E, 1'b1);

        // R8: reset mid-run overrides an asserted load
        rst_n = 1'b0; load_n = 1'b0; a_in = 12'hBEE;
        @(posedge clk);
        @(negedge clk);
        check_out("R8", 12'h000, 1'b1);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_out("R3", 12'hBEE, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule